// File: doc/BRIEF.md
# Single-Channel Memory-to-Peripheral DMA Engine

This block is one DMA channel. Software loads a source address, a destination address, a cycle count and a control word through a small word-addressed register port. When the enable bit is set, the engine moves data on a single bus master port. Each beat is one read followed by one write of the data just read. Each side can step its address up or down by a signed amount after every beat. Each side can also be placed on either the system bus or the peripheral bus.

A channel can be tied to slow peripherals through up to fifteen request/grant line pairs. Before each cycle the engine waits for the selected request lines. When the cycle is done it pulses the matching grants. The count register counts down live, so software can read the remaining work at any time. Completion and bus errors are reported as status bits in the control word, and each can be routed to the interrupt output.

Top module: `dmac_chan`

## Requirements
- R1: Register word 0 holds the source address, word 1 the destination address, word 2 the cycle count (CNT_W bits, upper bits read 0) and word 3 the control word. Control bits 11, 15, 22, 23 and 28 to 31 always read 0.
- R2: Writing the control word with finish status (bit 1) or error status (bit 4) at 0 clears that bit. Writing a 1 there leaves it unchanged, so software can never set a status bit.
- R3: Setting enable (bit 0) with a nonzero count starts the transfer. Each beat reads the source address (m_we=0) and then writes the data it read to the destination address (m_we=1). Each access holds m_req, m_addr and m_we steady until m_ack.
- R4: Control bits 10:8 (source) and 14:12 (destination) give the address change applied after every completed beat. The codes are: 000 and 100 mean no change; 001, 010 and 011 mean +1, +2 and +4 bytes; 101, 110 and 111 mean -1, -2 and -4 bytes.
- R5: With burst (bit 3) set, one cycle is four beats, so each address moves by four times its step per cycle. With burst clear, one cycle is one beat.
- R6: Control bits 21:20 drive m_size unchanged (00 word, 01 halfword, 10 byte). m_sys equals bit 6 during reads and bit 7 during writes (1 selects the system bus, 0 the peripheral bus).
- R7: The count decrements by one when the last write of a cycle is acknowledged, and software can read its current value while the transfer runs.
- R8: When the count reaches zero, finish status is set and enable clears. Enabling with a count of zero sets finish at once, with no bus access.
- R9: The destination request number is in bits 19:16 and the source request number is in bits 27:24. A value n from 1 to LINES selects dreq[n-1]; 0 selects no line. Before each cycle the engine waits until every selected request is high. One clock after the cycle's last write acknowledge, it pulses the selected grants for exactly one clock.
- R10: An access acknowledged with m_err ends the transfer. Error status is set, enable clears, the count and the address of the failed access are not advanced, and no further access is issued.
- R11: irq is high exactly when (finish status AND bit 2) OR (error status AND bit 5).
- R12: Clearing enable while the engine waits for a request stops it. No access follows, even if the request later arrives.
- R13: After reset all registers read 0, m_req is low, all grants are low and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_word | input | 2 | Register word index (0 to 3) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| m_req | output | 1 | Bus access request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_sys | output | 1 | 1 = system bus, 0 = peripheral bus |
| m_addr | output | AW | Access address |
| m_size | output | 2 | Access width code |
| m_wdata | output | 32 | Write data |
| m_ack | input | 1 | Access complete |
| m_err | input | 1 | Error response, valid with m_ack |
| m_rdata | input | 32 | Read data, valid with m_ack |
| dreq | input | LINES | Peripheral request lines |
| dgrant | output | LINES | Peripheral grant pulses |
| irq | output | 1 | Interrupt |

## Verification
The assertions check, on every cycle, the properties that hold whatever the program:
- a pending access stays stable until it is acknowledged;
- the count only ever steps down by one unless software writes it;
- finish status never rises while enable stays set;
- an error response always stops the engine;
- a grant always follows a completed write;
- irq is never high without a status bit.

Only the directed scenarios can show the values themselves:
- that the copied data lands where the step codes say;
- that a burst cycle takes four beats;
- the size and bus-select values on each access;
- the exact number of grants;
- the count read partway through a gated transfer;
- that status bits cannot be set by software.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RD, S_WR} seq_t;

   // control word bit positions
   localparam int CB_EN    = 0;
   localparam int CB_FIN   = 1;
   localparam int CB_FIE   = 2;
   localparam int CB_BURST = 3;
   localparam int CB_ERR   = 4;
   localparam int CB_EIE   = 5;
   localparam int CB_SSYS  = 6;
   localparam int CB_DSYS  = 7;
   localparam int CB_SSTEP = 8;
   localparam int CB_DSTEP = 12;
   localparam int CB_DNO   = 16;
   localparam int CB_WID   = 20;
   localparam int CB_SNO   = 24;

   localparam logic [31:0] CTL_MASK = 32'h0F3F_77FF;
   localparam int BURST_LEN = 4;
   localparam int BEAT_W = $clog2(BURST_LEN);

   // signed byte step for a 3-bit code; 100 is reserved and means no change
   function automatic logic signed [3:0] step_decode(input logic [2:0] code);
      case (code)
         3'b001:  return 4'sd1;
         3'b010:  return 4'sd2;
         3'b011:  return 4'sd4;
         3'b101:  return -4'sd1;
         3'b110:  return -4'sd2;
         3'b111:  return -4'sd4;
         default: return 4'sd0;
      endcase
   endfunction
endpackage

// File: rtl/dmac_stepper.sv
module dmac_stepper #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr_i,
   input  logic [2:0]    code_i,
   output logic [AW-1:0] addr_o
);
   logic signed [3:0] delta;

   assign delta  = dmac_pkg::step_decode(code_i);
   assign addr_o = addr_i + {{(AW-4){delta[3]}}, delta};
endmodule

// File: rtl/dmac_reqsel.sv
module dmac_reqsel #(
   parameter int LINES = 15
) (
   input  logic [3:0]       src_no,
   input  logic [3:0]       dst_no,
   input  logic [LINES-1:0] req,
   output logic [LINES-1:0] mask,
   output logic             req_ok
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign mask[i] = (src_no == 4'(i + 1)) || (dst_no == 4'(i + 1));
   end

   assign req_ok = ((req & mask) == mask);
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
   import dmac_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic burst,
   input  logic cnt_zero,
   input  logic cnt_one,
   input  logic req_ok,
   input  logic m_ack,
   input  logic m_err,
   output seq_t state,
   output logic rd_done,
   output logic wr_done,
   output logic cyc_done,
   output logic fin_evt,
   output logic err_evt
);
   seq_t state_q, state_d;
   logic [BEAT_W-1:0] beat_q, beat_d;

   always_comb begin
      state_d  = state_q;
      beat_d   = beat_q;
      rd_done  = 1'b0;
      wr_done  = 1'b0;
      cyc_done = 1'b0;
      fin_evt  = 1'b0;
      err_evt  = 1'b0;
      case (state_q)
         S_IDLE: begin
            if (en) begin
               if (cnt_zero) fin_evt = 1'b1;
               else          state_d = S_WAIT;
            end
         end
         S_WAIT: begin
            if (!en) state_d = S_IDLE;
            else if (req_ok) begin
               state_d = S_RD;
               beat_d  = '0;
            end
         end
         S_RD: begin
            if (m_ack) begin
               if (m_err) begin
                  err_evt = 1'b1;
                  state_d = S_IDLE;
               end else begin
                  rd_done = 1'b1;
                  state_d = S_WR;
               end
            end
         end
         default: begin
            if (m_ack) begin
               if (m_err) begin
                  err_evt = 1'b1;
                  state_d = S_IDLE;
               end else begin
                  wr_done = 1'b1;
                  if (!burst || beat_q == BEAT_W'(BURST_LEN - 1)) begin
                     cyc_done = 1'b1;
                     if (cnt_one) begin
                        fin_evt = 1'b1;
                        state_d = S_IDLE;
                     end else begin
                        state_d = S_WAIT;
                     end
                  end else begin
                     beat_d  = beat_q + 1'b1;
                     state_d = S_RD;
                  end
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         beat_q  <= beat_d;
      end
   end

   assign state = state_q;
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
   import dmac_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 24,
   parameter int LINES = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_word,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   output logic             m_req,
   output logic             m_we,
   output logic             m_sys,
   output logic [AW-1:0]    m_addr,
   output logic [1:0]       m_size,
   output logic [31:0]      m_wdata,
   input  logic             m_ack,
   input  logic             m_err,
   input  logic [31:0]      m_rdata,
   input  logic [LINES-1:0] dreq,
   output logic [LINES-1:0] dgrant,
   output logic             irq
);
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("dmac_chan: AW must lie in 8..32");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("dmac_chan: CNT_W must lie in 2..32");
   end
   if (LINES < 1 || LINES > 15) begin : g_bad_lines
      $error("dmac_chan: LINES must lie in 1..15");
   end

   logic [AW-1:0]    src_q, dst_q;
   logic [CNT_W-1:0] cnt_q;
   logic [31:0]      ctl_q, ctl_d, data_q;
   logic [LINES-1:0] gnt_q, line_mask;
   logic             req_ok;
   seq_t             st;
   logic             rd_done, wr_done, cyc_done, fin_evt, err_evt;

   logic [AW-1:0] step_cur  [2];
   logic [AW-1:0] step_nxt  [2];
   logic [2:0]    step_code [2];

   assign step_cur[0]  = src_q;
   assign step_cur[1]  = dst_q;
   assign step_code[0] = ctl_q[CB_SSTEP +: 3];
   assign step_code[1] = ctl_q[CB_DSTEP +: 3];

   for (genvar s = 0; s < 2; s++) begin : g_step
      dmac_stepper #(.AW(AW)) u_step (
         .addr_i(step_cur[s]),
         .code_i(step_code[s]),
         .addr_o(step_nxt[s])
      );
   end

   dmac_reqsel #(.LINES(LINES)) u_reqsel (
      .src_no(ctl_q[CB_SNO +: 4]),
      .dst_no(ctl_q[CB_DNO +: 4]),
      .req(dreq),
      .mask(line_mask),
      .req_ok(req_ok)
   );

   dmac_seq u_seq (
      .clk(clk),
      .rst_n(rst_n),
      .en(ctl_q[CB_EN]),
      .burst(ctl_q[CB_BURST]),
      .cnt_zero(cnt_q == '0),
      .cnt_one(cnt_q == CNT_W'(1)),
      .req_ok(req_ok),
      .m_ack(m_ack),
      .m_err(m_err),
      .state(st),
      .rd_done(rd_done),
      .wr_done(wr_done),
      .cyc_done(cyc_done),
      .fin_evt(fin_evt),
      .err_evt(err_evt)
   );

   // control word: software write, then engine events take priority
   always_comb begin
      ctl_d = ctl_q;
      if (cfg_wr && cfg_word == 2'd3) begin
         ctl_d         = cfg_wdata & CTL_MASK;
         ctl_d[CB_FIN] = ctl_q[CB_FIN] & cfg_wdata[CB_FIN];
         ctl_d[CB_ERR] = ctl_q[CB_ERR] & cfg_wdata[CB_ERR];
      end
      if (fin_evt) begin
         ctl_d[CB_FIN] = 1'b1;
         ctl_d[CB_EN]  = 1'b0;
      end
      if (err_evt) begin
         ctl_d[CB_ERR] = 1'b1;
         ctl_d[CB_EN]  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         ctl_q  <= '0;
         data_q <= '0;
         gnt_q  <= '0;
      end else begin
         ctl_q <= ctl_d;
         gnt_q <= cyc_done ? line_mask : '0;
         if (rd_done) data_q <= m_rdata;
         if (cfg_wr && cfg_word == 2'd0) src_q <= cfg_wdata[AW-1:0];
         else if (wr_done)               src_q <= step_nxt[0];
         if (cfg_wr && cfg_word == 2'd1) dst_q <= cfg_wdata[AW-1:0];
         else if (wr_done)               dst_q <= step_nxt[1];
         if (cfg_wr && cfg_word == 2'd2) cnt_q <= cfg_wdata[CNT_W-1:0];
         else if (cyc_done)              cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      case (cfg_word)
         2'd0:    cfg_rdata = 32'(src_q);
         2'd1:    cfg_rdata = 32'(dst_q);
         2'd2:    cfg_rdata = 32'(cnt_q);
         default: cfg_rdata = ctl_q;
      endcase
   end

   assign m_req   = (st == S_RD) || (st == S_WR);
   assign m_we    = (st == S_WR);
   assign m_addr  = m_we ? dst_q : src_q;
   assign m_sys   = m_we ? ctl_q[CB_DSYS] : ctl_q[CB_SSYS];
   assign m_size  = ctl_q[CB_WID +: 2];
   assign m_wdata = data_q;
   assign dgrant  = gnt_q;
   assign irq     = (ctl_q[CB_FIN] & ctl_q[CB_FIE]) | (ctl_q[CB_ERR] & ctl_q[CB_EIE]);
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
   parameter int AW    = 32,
   parameter int CNT_W = 24,
   parameter int LINES = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             m_req,
   input logic             m_we,
   input logic             m_ack,
   input logic             m_err,
   input logic [AW-1:0]    m_addr,
   input logic [LINES-1:0] dgrant,
   input logic             irq,
   input logic             cfg_wr,
   input logic [CNT_W-1:0] cnt_q,
   input logic [31:0]      ctl_q
);
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we));

   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) && !$past(cfg_wr) |-> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

   p_fin_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q[1]) |-> !ctl_q[0]);

   p_grant_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|dgrant) |-> $past(m_req && m_we && m_ack && !m_err));

   p_err_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      m_req && m_ack && m_err |=> ctl_q[4] && !ctl_q[0] && !m_req);

   p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctl_q[1] || ctl_q[4]);
endmodule

bind dmac_chan dmac_chk #(.AW(AW), .CNT_W(CNT_W), .LINES(LINES)) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .m_req(m_req),
   .m_we(m_we),
   .m_ack(m_ack),
   .m_err(m_err),
   .m_addr(m_addr),
   .dgrant(dgrant),
   .irq(irq),
   .cfg_wr(cfg_wr),
   .cnt_q(cnt_q),
   .ctl_q(ctl_q)
);

// File: tb/sim_dmac_chan.sv
`timescale 1ns/1ps
module sim_dmac_chan;
   localparam int AW = 32, CNT_W = 24, LINES = 15;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [1:0] cfg_word = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic m_req, m_we, m_sys, m_ack, m_err;
   logic [AW-1:0] m_addr;
   logic [1:0] m_size;
   logic [31:0] m_wdata, m_rdata;
   logic [LINES-1:0] dreq = '0, dgrant;
   logic irq;

   always #4 clk = ~clk;

   dmac_chan #(.AW(AW), .CNT_W(CNT_W), .LINES(LINES)) u0 (.*);

   // bus model and access log
   logic [31:0] mem [0:63];
   logic [31:0] log_addr [0:63];
   logic        log_we [0:63];
   logic [1:0]  log_size [0:63];
   logic        log_sys [0:63];
   int log_n = 0, gnt_cnt = 0, gnt_bad = 0;
   logic err_on = 1'b0;
   logic [31:0] err_addr = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ack <= 1'b0;
         m_err <= 1'b0;
         m_rdata <= '0;
         for (int i = 0; i < 64; i++) mem[i] <= 32'h1000_0000 + i;
      end else begin
         m_ack <= m_req && !m_ack;
         m_err <= m_req && !m_ack && err_on && (m_addr == err_addr);
         if (m_req && !m_ack) m_rdata <= mem[m_addr[7:2]];
         if (m_req && m_ack) begin
            if (m_we && !m_err) mem[m_addr[7:2]] <= m_wdata;
            log_addr[log_n[5:0]] <= m_addr;
            log_we[log_n[5:0]]   <= m_we;
            log_size[log_n[5:0]] <= m_size;
            log_sys[log_n[5:0]]  <= m_sys;
            log_n <= log_n + 1;
         end
         if (dgrant[2]) gnt_cnt <= gnt_cnt + 1;
         if ((dgrant & ~(LINES'(1) << 2)) != '0) gnt_bad <= gnt_bad + 1;
      end
   end

   int n_chk = 0, n_err = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] w, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_word = w; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] w, output logic [31:0] d);
      @(negedge clk);
      cfg_word = w;
      #1 d = cfg_rdata;
   endtask

   task automatic start(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n,
                        input logic [31:0] c);
      reg_wr(2'd0, s); reg_wr(2'd1, d); reg_wr(2'd2, n); reg_wr(2'd3, c);
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] v;
      int t = 0;
      do begin
         reg_rd(2'd3, v);
         t++;
      end while (v[0] && t < 2000);
      chk({tag, " transfer ends"}, 32'(v[0]), 32'd0);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int w = 0; w < 4; w++) begin
         reg_rd(2'(w), v);
         chk("R13 register after reset", v, 32'd0);
      end
      chk("R13 irq/m_req after reset", {30'd0, irq, m_req}, 32'd0);
      chk("R13 grants after reset", 32'(dgrant), 32'd0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      reg_wr(2'd0, 32'h1234_5678); reg_rd(2'd0, v); chk("R1 source word", v, 32'h1234_5678);
      reg_wr(2'd1, 32'h9ABC_DEF0); reg_rd(2'd1, v); chk("R1 destination word", v, 32'h9ABC_DEF0);
      reg_wr(2'd2, 32'hFFFF_FFFF); reg_rd(2'd2, v); chk("R1 count width", v, 32'h00FF_FFFF);
      reg_wr(2'd3, 32'hFFFF_FFFE); reg_rd(2'd3, v); chk("R1 R2 control mask", v, 32'h0F3F_77EC);
      reg_wr(2'd3, 32'd0);
      reg_wr(2'd2, 32'd0);
   endtask

   task automatic t_copy();
      logic [31:0] v;
      int l0 = log_n;
      start(32'h00, 32'h40, 32'd4, 32'h0000_3305);
      wait_idle("R3");
      for (int k = 0; k < 4; k++) chk("R3 copied word", mem[16 + k], 32'h1000_0000 + k);
      chk("R3 access count", 32'(log_n - l0), 32'd8);
      chk("R3 read then write", {30'd0, log_we[(l0 + 1) % 64], log_we[l0 % 64]}, 32'd2);
      chk("R3 first write address", log_addr[(l0 + 1) % 64], 32'h40);
      reg_rd(2'd0, v); chk("R4 source +4 steps", v, 32'h10);
      reg_rd(2'd1, v); chk("R4 destination +4 steps", v, 32'h50);
      reg_rd(2'd2, v); chk("R7 count at end", v, 32'd0);
      reg_rd(2'd3, v); chk("R8 finish set, enable clear", v, 32'h0000_3306);
      chk("R11 irq on finish", 32'(irq), 32'd1);
      reg_wr(2'd3, 32'h0000_3306); reg_rd(2'd3, v); chk("R2 write 1 keeps status", v, 32'h0000_3306);
      reg_wr(2'd3, 32'h0000_3304); reg_rd(2'd3, v); chk("R2 write 0 clears status", v, 32'h0000_3304);
      chk("R11 irq after clear", 32'(irq), 32'd0);
      reg_wr(2'd3, 32'h0000_3306); reg_rd(2'd3, v); chk("R2 status cannot be set", v, 32'h0000_3304);
   endtask

   task automatic t_burst();
      logic [31:0] v;
      int l0 = log_n;
      start(32'h3C, 32'h80, 32'd2, 32'h0000_3709);
      wait_idle("R5");
      chk("R5 beats in two burst cycles", 32'(log_n - l0), 32'd16);
      for (int k = 0; k < 8; k++) chk("R5 R4 descending copy", mem[32 + k], 32'h1000_0000 + 15 - k);
      reg_rd(2'd0, v); chk("R5 source moved 8 x -4", v, 32'h1C);
      reg_rd(2'd1, v); chk("R5 destination moved 8 x +4", v, 32'hA0);
      chk("R11 no irq without finish enable", 32'(irq), 32'd0);
   endtask

   task automatic t_steps();
      logic [31:0] v;
      int l0 = log_n;
      start(32'h00, 32'hC0, 32'd3, 32'h0020_4141);
      wait_idle("R4");
      reg_rd(2'd0, v); chk("R4 code 001 steps +1", v, 32'h03);
      reg_rd(2'd1, v); chk("R4 reserved code 100 holds", v, 32'hC0);
      for (int k = 0; k < 6; k++) begin
         chk("R6 byte size code", 32'(log_size[(l0 + k) % 64]), 32'd2);
         chk("R6 bus select per side", 32'(log_sys[(l0 + k) % 64]), (k % 2 == 0) ? 32'd1 : 32'd0);
      end
      l0 = log_n;
      start(32'h00, 32'hD0, 32'd2, 32'h0010_6281);
      wait_idle("R4");
      reg_rd(2'd0, v); chk("R4 code 010 steps +2", v, 32'h04);
      reg_rd(2'd1, v); chk("R4 code 110 steps -2", v, 32'hCC);
      chk("R6 halfword size code", 32'(log_size[l0 % 64]), 32'd1);
      chk("R6 destination on system bus", 32'(log_sys[(l0 + 1) % 64]), 32'd1);
   endtask

   task automatic t_zero();
      logic [31:0] v;
      int l0 = log_n;
      start(32'h00, 32'h00, 32'd0, 32'h0000_0001);
      repeat (4) @(negedge clk);
      reg_rd(2'd3, v); chk("R8 zero count finishes at once", v & 32'h3, 32'd2);
      chk("R8 zero count makes no access", 32'(log_n - l0), 32'd0);
   endtask

   task automatic t_grant();
      logic [31:0] v;
      int l0 = log_n, g0 = gnt_cnt, t = 0;
      start(32'h00, 32'hFC, 32'd5, 32'h0003_0001);
      repeat (20) @(negedge clk);
      chk("R9 waits on low request", 32'(log_n - l0), 32'd0);
      reg_rd(2'd2, v); chk("R9 count held while waiting", v, 32'd5);
      dreq[2] = 1'b1;
      while (!dgrant[2] && t < 200) begin @(negedge clk); t++; end
      dreq[2] = 1'b0;
      repeat (10) @(negedge clk);
      reg_rd(2'd2, v); chk("R7 live count mid transfer", v, 32'd4);
      chk("R9 one grant per cycle", 32'(gnt_cnt - g0), 32'd1);
      dreq[2] = 1'b1;
      wait_idle("R9");
      dreq[2] = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 grant total", 32'(gnt_cnt - g0), 32'd5);
      chk("R9 no foreign grant", 32'(gnt_bad), 32'd0);
   endtask

   task automatic t_abort();
      logic [31:0] v;
      int l0 = log_n;
      reg_wr(2'd3, 32'd0);
      start(32'h00, 32'hFC, 32'd2, 32'h0003_0001);
      repeat (5) @(negedge clk);
      reg_wr(2'd3, 32'h0003_0000);
      repeat (3) @(negedge clk);
      dreq[2] = 1'b1;
      repeat (10) @(negedge clk);
      chk("R12 no access after disable", 32'(log_n - l0), 32'd0);
      reg_rd(2'd2, v); chk("R12 count untouched", v, 32'd2);
      dreq[2] = 1'b0;
   endtask

   task automatic t_error();
      logic [31:0] v;
      int l0;
      err_addr = 32'hE8; err_on = 1'b1;
      l0 = log_n;
      start(32'h00, 32'hE0, 32'd4, 32'h0000_3321);
      wait_idle("R10");
      repeat (10) @(negedge clk);
      chk("R10 accesses up to the error", 32'(log_n - l0), 32'd6);
      reg_rd(2'd3, v); chk("R10 error set, enable clear", v, 32'h0000_3330);
      reg_rd(2'd2, v); chk("R10 count not advanced", v, 32'd2);
      reg_rd(2'd1, v); chk("R10 failed address kept", v, 32'hE8);
      chk("R11 irq on error", 32'(irq), 32'd1);
      err_on = 1'b0;
      reg_wr(2'd3, 32'h0000_3320);
      chk("R11 irq after error clear", 32'(irq), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_copy();
      t_burst();
      t_steps();
      t_zero();
      t_grant();
      t_abort();
      t_error();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule